// File: doc/BRIEF.md
# I2C Bit-Level to Byte-Transaction Bridge

This block sits on the target side of a two-wire serial bus. It watches the clock (SCL) and data (SDA) levels and turns their activity into byte-level requests on a plain parallel back-end port. The block does not own a bus address. Every address byte is passed to the back end, and the back end's accept or reject reply decides whether the block acknowledges. One instance can therefore stand in for a whole set of targets behind it.

Both lines are brought into the system clock domain through two-flop synchronisers. Each line also keeps a registered copy of its last level. Edges and bus conditions are found by comparing the synchronised level with that stored copy. The block's own SDA drive is combined with the controller's synchronised SDA level by a wired-AND, and the result is driven out on `sda_o`.

A request is a single-cycle strobe that carries an opcode. The opcodes are start-with-address (0), write-byte (1), read-byte (2), NACK-notify (3) and end-transfer (4). Start, write and read wait for a one-cycle response, which must arrive while SCL is still high in the clock that raised the request. NACK-notify and end-transfer need no response.

Top module: `i2c_bridge`

## Requirements
- R1: SDA falling while SCL is high is a START. It clears any held address, and the next eight rising SCL edges shift in a fresh address byte. A repeated START mid-transfer behaves the same way and issues no end-transfer request.
- R2: SDA rising while SCL is high is a STOP and returns the block to idle. An end-transfer request (op 4) is issued only if an address has been accepted since the last START. Otherwise no request is issued.
- R3: Data bits are sampled on rising SCL edges, MSB first. The block's own SDA drive is released to 1 on every falling SCL edge.
- R4: On the rising edge of the ninth clock after START, the block requests start-with-address (op 0), with `req_addr_o` = byte bits 7:1 and `req_rnw_o` = byte bit 0. For each later byte in a write phase, it requests write-byte (op 1) with `req_data_o` = the byte.
- R5: If the back end accepts, the block pulls `sda_o` low for the rest of that ninth-clock high period. If it rejects, SDA stays released and the block goes idle. A rejected write-byte also issues end-transfer at once, because an address is already held. A rejected address issues nothing more.
- R6: After an accepted address with read flag 1, the first rising SCL edge of each read byte issues read-byte (op 2). The returned byte appears on `sda_o` MSB first, one new bit per rising SCL edge.
- R7: On the rising edge after eight read bits, a low SDA from the controller starts the next read byte. A high SDA issues NACK-notify (op 3). After that, clocks are ignored (`sda_o` stays high, no request) until STOP or START. A STOP there issues end-transfer.
- R8: While idle, SCL and SDA activity other than a START issues no request and leaves the block's drive released.
- R9: `sda_o` is the block's drive ANDed with the synchronised controller SDA level. After reset, `sda_o` is 1 and no request is pending.
- R10: `req_valid_o` is a one-cycle strobe. Exactly the requests listed in R2 to R7 are issued, with no extra request.
- R11: SDA changes while SCL is low only update the stored SDA level. They never count as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level from the controller |
| sda_i | input | 1 | Bus data level driven by the controller |
| sda_o | output | 1 | Resolved data line: own drive AND controller level |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_op_o | output | 3 | Opcode: 0 start, 1 write, 2 read, 3 NACK-notify, 4 end |
| req_addr_o | output | 7 | Target address for a start request |
| req_rnw_o | output | 1 | Read flag for a start request |
| req_data_o | output | 8 | Byte for a write request |
| rsp_valid_i | input | 1 | One-cycle response strobe |
| rsp_reject_i | input | 1 | Response rejects the request |
| rsp_data_i | input | 8 | Byte returned for a read request |

## Verification
The bench runs a multi-byte write, a rejected address, a rejected data byte, a read ended by a controller NACK with trailing clocks, and a write followed by a repeated START into a read. Together these separate the address path from the data path, the accept case from the two reject cases, and STOP with an address held from STOP without one. The idle sequence toggles SDA only while SCL is low and then pulses SCL. Any request seen there shows a false START or STOP, or an idle state that reacts to clocks. The read bytes 0xA5, 0x3C and 0x81 have alternating and edge-heavy bit patterns, so any error in bit order or bit count shows up on `sda_o`.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_NACK  = 3'd3,
    OP_END   = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_WAIT_ACK,
    ST_TX_FIRST,
    ST_WAIT_RD,
    ST_TX,
    ST_TX_ACK,
    ST_NACKED
  } state_e;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2cb_line_events.sv
module i2cb_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic sda_lvl_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  logic scl_high;
  assign scl_high = scl_q & scl_s_i;

  assign start_o   = scl_high &  sda_q & ~sda_s_i;
  assign stop_o    = scl_high & ~sda_q &  sda_s_i;
  // bus conditions win over clock edges
  assign rise_o    = ~scl_q &  scl_s_i & ~(start_o | stop_o);
  assign fall_o    =  scl_q & ~scl_s_i & ~(start_o | stop_o);
  assign sda_lvl_o = sda_q;
endmodule

// File: rtl/i2cb_fsm.sv
module i2cb_fsm
  import i2cb_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_lvl_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_reject_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  output logic              drive_o,
  output state_e            state_o,
  output logic              req_valid_o,
  output op_e               req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_rnw_o,
  output logic [BYTE_W-1:0] req_data_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              have_addr_q;
  logic              drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      have_addr_q <= 1'b0;
      drive_q     <= 1'b1;
      req_valid_o <= 1'b0;
      req_op_o    <= OP_END;
      req_addr_o  <= '0;
      req_rnw_o   <= 1'b0;
      req_data_o  <= '0;
    end else begin
      req_valid_o <= 1'b0;
      if (start_i) begin
        state_q     <= ST_RX;
        cnt_q       <= '0;
        have_addr_q <= 1'b0;
        drive_q     <= 1'b1;
      end else if (stop_i) begin
        if (have_addr_q) begin
          req_valid_o <= 1'b1;
          req_op_o    <= OP_END;
        end
        have_addr_q <= 1'b0;
        state_q     <= ST_IDLE;
        drive_q     <= 1'b1;
      end else begin
        // back-end replies
        if (rsp_valid_i) begin
          case (state_q)
            ST_WAIT_ACK: begin
              if (rsp_reject_i) begin
                if (have_addr_q) begin
                  req_valid_o <= 1'b1;
                  req_op_o    <= OP_END;
                end
                have_addr_q <= 1'b0;
                state_q     <= ST_IDLE;
                drive_q     <= 1'b1;
              end else begin
                drive_q <= 1'b0;
                cnt_q   <= '0;
                if (!have_addr_q) begin
                  have_addr_q <= 1'b1;
                  state_q     <= shreg_q[0] ? ST_TX_FIRST : ST_RX;
                end else begin
                  state_q <= ST_RX;
                end
              end
            end
            ST_WAIT_RD: begin
              if (rsp_reject_i) begin
                req_valid_o <= 1'b1;
                req_op_o    <= OP_END;
                have_addr_q <= 1'b0;
                state_q     <= ST_IDLE;
                drive_q     <= 1'b1;
              end else begin
                drive_q <= rsp_data_i[BYTE_W-1];
                shreg_q <= {rsp_data_i[BYTE_W-2:0], 1'b0};
                cnt_q   <= CNT_W'(1);
                state_q <= ST_TX;
              end
            end
            default: ;
          endcase
        end

        if (rise_i) begin
          case (state_q)
            ST_RX: begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
              drive_q <= 1'b1;
              if (cnt_q == LAST_BIT) state_q <= ST_RX_ACK;
              else                   cnt_q   <= cnt_q + 1'b1;
            end
            ST_RX_ACK: begin
              req_valid_o <= 1'b1;
              if (!have_addr_q) begin
                req_op_o   <= OP_START;
                req_addr_o <= shreg_q[BYTE_W-1:1];
                req_rnw_o  <= shreg_q[0];
              end else begin
                req_op_o   <= OP_WRITE;
                req_data_o <= shreg_q;
              end
              state_q <= ST_WAIT_ACK;
            end
            ST_TX_FIRST: begin
              req_valid_o <= 1'b1;
              req_op_o    <= OP_READ;
              state_q     <= ST_WAIT_RD;
            end
            ST_TX: begin
              drive_q <= shreg_q[BYTE_W-1];
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              if (cnt_q == LAST_BIT) state_q <= ST_TX_ACK;
              else                   cnt_q   <= cnt_q + 1'b1;
            end
            ST_TX_ACK: begin
              drive_q <= 1'b1;
              if (sda_lvl_i) begin
                req_valid_o <= 1'b1;
                req_op_o    <= OP_NACK;
                state_q     <= ST_NACKED;
              end else begin
                state_q <= ST_TX_FIRST;
              end
            end
            default: ;
          endcase
        end

        if (fall_i) drive_q <= 1'b1;
      end
    end
  end

  assign drive_o = drive_q;
  assign state_o = state_q;
endmodule

// File: rtl/i2c_bridge.sv
module i2c_bridge
  import i2cb_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int N_LINES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              req_valid_o,
  output logic [2:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_rnw_o,
  output logic [BYTE_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_reject_i,
  input  logic [BYTE_W-1:0] rsp_data_i
);
  logic [N_LINES-1:0] line_raw, line_s;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  logic evt_start, evt_stop, evt_rise, evt_fall, sda_lvl;

  i2cb_line_events u_events (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_s_i  (line_s[0]),
    .sda_s_i  (line_s[1]),
    .start_o  (evt_start),
    .stop_o   (evt_stop),
    .rise_o   (evt_rise),
    .fall_o   (evt_fall),
    .sda_lvl_o(sda_lvl)
  );

  logic   drive;
  state_e state;
  op_e    req_op;

  i2cb_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (evt_start),
    .stop_i      (evt_stop),
    .rise_i      (evt_rise),
    .fall_i      (evt_fall),
    .sda_lvl_i   (sda_lvl),
    .rsp_valid_i (rsp_valid_i),
    .rsp_reject_i(rsp_reject_i),
    .rsp_data_i  (rsp_data_i),
    .drive_o     (drive),
    .state_o     (state),
    .req_valid_o (req_valid_o),
    .req_op_o    (req_op),
    .req_addr_o  (req_addr_o),
    .req_rnw_o   (req_rnw_o),
    .req_data_o  (req_data_o)
  );

  assign req_op_o = req_op;
  assign sda_o    = drive & sda_lvl;
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
  import i2cb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_o,
  input logic [2:0] req_op_o,
  input logic       rsp_valid_i,
  input logic       rsp_reject_i,
  input logic       drive,
  input state_e     state,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       evt_fall
);
  logic last_was_start, accepted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_was_start <= 1'b0;
      accepted       <= 1'b0;
    end else begin
      if (req_valid_o) last_was_start <= (req_op_o == OP_START);
      if (evt_start || (req_valid_o && req_op_o == OP_END)) accepted <= 1'b0;
      else if (rsp_valid_i && !rsp_reject_i && last_was_start) accepted <= 1'b1;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o); // R10

  AST_END_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == OP_END) |-> accepted); // R2

  AST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_fall |=> drive); // R3

  AST_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT_ACK && rsp_valid_i && !rsp_reject_i && !evt_start && !evt_stop && !evt_fall)
    |=> !drive); // R5

  AST_REJECT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT_ACK && rsp_valid_i && rsp_reject_i && !evt_start && !evt_stop)
    |=> (drive && state == ST_IDLE)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !evt_start) |=> !req_valid_o); // R8

  AST_NACKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_NACKED && !evt_stop) |=> (!req_valid_o && drive)); // R7
endmodule

bind i2c_bridge i2cb_checker i_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_op_o    (req_op_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_reject_i(rsp_reject_i),
  .drive       (drive),
  .state       (state),
  .evt_start   (evt_start),
  .evt_stop    (evt_stop),
  .evt_fall    (evt_fall)
);

// File: tb/test_i2c_bridge.sv
module test_i2c_bridge;
  localparam int HALF    = 12;
  localparam int RSP_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic sda_o, req_valid, req_rnw, rsp_valid, rsp_reject;
  logic [2:0] req_op;
  logic [6:0] req_addr;
  logic [7:0] req_data, rsp_data;

  always #5 clk = ~clk;

  i2c_bridge i_i2c_bridge (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o),
    .req_valid_o(req_valid), .req_op_o(req_op), .req_addr_o(req_addr),
    .req_rnw_o(req_rnw), .req_data_o(req_data),
    .rsp_valid_i(rsp_valid), .rsp_reject_i(rsp_reject), .rsp_data_i(rsp_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] val;
    logic       rej;
    logic [7:0] rdata;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] val, input logic rej,
                      input logic [7:0] rdata, input string tag);
    exp_q.push_back('{op: op, val: val, rej: rej, rdata: rdata});
    tag_q.push_back(tag);
  endtask

  // monitor and back-end model
  initial begin
    int   pend = 0;
    exp_t cur = '0;
    rsp_valid  = 1'b0;
    rsp_reject = 1'b0;
    rsp_data   = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid  = 1'b1;
          rsp_reject = cur.rej;
          rsp_data   = cur.rdata;
        end
      end
      if (rst_n && req_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected request op", int'(req_op), 7);
        end else begin
          exp_t  e;
          string t;
          logic [7:0] got;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          got = (req_op == 3'd0) ? {req_addr, req_rnw} :
                (req_op == 3'd1) ? req_data : 8'h00;
          check(req_op == e.op, t, "request op", int'(req_op), int'(e.op));
          check(got == e.val, t, "request value", int'(got), int'(e.val));
          if (e.op <= 3'd2) begin
            cur  = e;
            pend = RSP_LAT;
          end
        end
      end
    end
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; half(); scl = 1'b1; half();
    sda = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda = 1'b0; half(); scl = 1'b1; half(); sda = 1'b1; half();
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda = b; half();
    scl = 1'b1;
    repeat (HALF - 2) @(negedge clk);
    seen = sda_o;
    repeat (2) @(negedge clk);
    scl = 1'b0; half();
  endtask

  task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(b[i], s);
      check(s == b[i], "R9", "resolved sda during write bit", int'(s), int'(b[i]));
    end
    clock_bit(1'b1, s);
    check(s == !exp_ack, tag, "ack slot level", int'(s), int'(!exp_ack));
    check(sda_o == 1'b1, "R3", "drive released after falling edge", int'(sda_o), 1);
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit ctrl_ack, input string tag);
    logic [7:0] got;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      got[i] = s;
    end
    check(got == exp, tag, "read byte on sda", int'(got), int'(exp));
    clock_bit(ctrl_ack ? 1'b0 : 1'b1, s);
  endtask

  task automatic drain(input string tag);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending expected requests", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    repeat (4) @(negedge clk);
    check(sda_o == 1'b1, "R9", "sda_o after reset", int'(sda_o), 1);
    check(req_valid == 1'b0, "R9", "req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sda_o == 1'b1, "R9", "sda_o idle after reset", int'(sda_o), 1);

    // idle: SDA toggles only while SCL low, then SCL pulses
    scl = 1'b0; half();
    for (int i = 0; i < 4; i++) begin
      sda = ~sda; half();
      check(sda_o == sda, "R11", "sda_o follows sda, scl low", int'(sda_o), int'(sda));
    end
    for (int i = 0; i < 3; i++) begin
      scl = 1'b1; half(); scl = 1'b0; half();
    end
    sda = 1'b1; half(); scl = 1'b1; half();
    check(sda_o == 1'b1, "R8", "idle drive released", int'(sda_o), 1);
    drain("R8");

    // multi-byte write
    push(3'd0, 8'hA0, 1'b0, 8'h00, "R4");
    push(3'd1, 8'h5A, 1'b0, 8'h00, "R4");
    push(3'd1, 8'hC3, 1'b0, 8'h00, "R4");
    push(3'd4, 8'h00, 1'b0, 8'h00, "R2");
    bus_start();
    write_byte(8'hA0, 1, "R5");
    write_byte(8'h5A, 1, "R5");
    write_byte(8'hC3, 1, "R5");
    bus_stop();
    drain("R2");

    // rejected address: no end-transfer
    push(3'd0, 8'h44, 1'b1, 8'h00, "R4");
    bus_start();
    write_byte(8'h44, 0, "R5");
    write_byte(8'h00, 0, "R8");
    bus_stop();
    drain("R2");

    // rejected data byte: end-transfer at once, none at STOP
    push(3'd0, 8'hA0, 1'b0, 8'h00, "R4");
    push(3'd1, 8'h11, 1'b1, 8'h00, "R4");
    push(3'd4, 8'h00, 1'b0, 8'h00, "R5");
    bus_start();
    write_byte(8'hA0, 1, "R5");
    write_byte(8'h11, 0, "R5");
    bus_stop();
    drain("R5");

    // read with controller ACK then NACK
    push(3'd0, 8'hA1, 1'b0, 8'h00, "R4");
    push(3'd2, 8'h00, 1'b0, 8'hA5, "R6");
    push(3'd2, 8'h00, 1'b0, 8'h3C, "R7");
    push(3'd3, 8'h00, 1'b0, 8'h00, "R7");
    push(3'd4, 8'h00, 1'b0, 8'h00, "R7");
    bus_start();
    write_byte(8'hA1, 1, "R5");
    read_byte(8'hA5, 1, "R6");
    read_byte(8'h3C, 0, "R6");
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      check(s == 1'b1, "R7", "sda_o after NACK", int'(s), 1);
    end
    bus_stop();
    drain("R7");

    // repeated START: write then read, no end-transfer between
    push(3'd0, 8'hA0, 1'b0, 8'h00, "R1");
    push(3'd1, 8'h07, 1'b0, 8'h00, "R4");
    push(3'd0, 8'hA1, 1'b0, 8'h00, "R1");
    push(3'd2, 8'h00, 1'b0, 8'h81, "R6");
    push(3'd3, 8'h00, 1'b0, 8'h00, "R7");
    push(3'd4, 8'h00, 1'b0, 8'h00, "R2");
    bus_start();
    write_byte(8'hA0, 1, "R5");
    write_byte(8'h07, 1, "R5");
    bus_start();
    write_byte(8'hA1, 1, "R1");
    read_byte(8'h81, 0, "R6");
    bus_stop();
    drain("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule